// File: doc/BRIEF.md
# Two-Subcarrier FSK Proximity Tag Waveform Generator

This block stands in for a low-frequency proximity tag. It turns a 44-bit identifier into an endless one-bit load-modulation stream. The stream is built from two subcarrier groups. The low group repeats `11000000` six times, which gives 48 samples. The high group repeats `1110000000` five times, which gives 50 samples. Each identifier bit is Manchester-coded as an ordered pair of these groups.

Every frame begins with a marker that breaks the Manchester rules. A short one-period separator comes before each run of four bits. The frame then repeats with no gap. The waveform moves forward by one sample on each carrier-clock enable pulse. While the block is disabled, the output is held low. When it is enabled again, the frame starts over at the marker.

Top module: `fsk_tag_gen`

## Requirements
- R1: While `rst_ni` is low or `en_i` is low, `wave_o` is 0.
- R2: A low group is 48 samples: `11000000` emitted 6 times, ones first.
- R3: A high group is 50 samples: `1110000000` emitted 5 times, ones first.
- R4: Each frame opens with eight groups in this order: low, low, low, high, high, high, low, high.
- R5: The identifier bits follow the marker from the highest index down to index 0. A 1 is a high group then a low group; a 0 is a low group then a high group.
- R6: One separator of 8 samples (`11000000`) is emitted just before each bit whose index modulo 4 equals 3.
- R7: The sample after the last sample of bit 0 is the first marker sample of the next frame, with no gap.
- R8: `id_i` is captured only on the tick that emits the first sample of a frame. A change of `id_i` in the middle of a frame has no effect on that frame.
- R9: The waveform advances one sample per `tick_i` pulse while enabled. `wave_o` is registered: it changes only at the edge where `tick_i` is high and stays stable otherwise.
- R10: After `en_i` returns high, the first tick emits the first marker sample of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Emission enable; low clears position and holds output low |
| tick_i | input | 1 | Carrier-clock enable, one sample per pulse |
| id_i | input | ID_W | Identifier to transmit, sampled at frame start |
| wave_o | output | 1 | Registered modulation sample |

## Verification
The bench builds the block with `ID_W = 12` and keeps the default subcarrier shapes. That gives a 1592-sample frame with three separators, so several complete frames fit easily in one run: a frame-to-frame wrap, a mid-frame identifier change, a disable in the middle of a frame, and a restart. Tick spacing varies from every cycle to every fourth cycle, which exercises the hold behaviour between pulses.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;
  typedef enum logic [1:0] {SEG_LO = 2'd0, SEG_HI = 2'd1, SEG_SEP = 2'd2} seg_e;
  typedef enum logic [1:0] {ST_SOF = 2'd0, ST_SEP = 2'd1, ST_BIT = 2'd2} st_e;
  localparam int unsigned SOF_GROUPS = 8;
  // bit k set: k-th marker group is the high (fc10) group
  localparam logic [SOF_GROUPS-1:0] SOF_HI_MASK = 8'b1011_1000;
endpackage

// File: rtl/fsk_tag_pat.sv
module fsk_tag_pat
  import fsk_tag_pkg::*;
#(
  parameter int unsigned LO_PER  = 8,
  parameter int unsigned LO_ONES = 2,
  parameter int unsigned LO_REPS = 6,
  parameter int unsigned HI_PER  = 10,
  parameter int unsigned HI_ONES = 3,
  parameter int unsigned HI_REPS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  seg_e kind_i,
  output logic bit_o,
  output logic last_o,
  output logic fresh_o
);
  localparam int unsigned MAX_PER = (LO_PER > HI_PER) ? LO_PER : HI_PER;
  localparam int unsigned MAX_REP = (LO_REPS > HI_REPS) ? LO_REPS : HI_REPS;
  localparam int unsigned PW = $clog2(MAX_PER + 1);
  localparam int unsigned RW = $clog2(MAX_REP + 1);

  logic [PW-1:0] ph_q, per_last, ones;
  logic [RW-1:0] rep_q, rep_last;

  always_comb begin
    unique case (kind_i)
      SEG_HI: begin
        per_last = PW'(HI_PER - 1);
        ones     = PW'(HI_ONES);
        rep_last = RW'(HI_REPS - 1);
      end
      SEG_SEP: begin
        per_last = PW'(LO_PER - 1);
        ones     = PW'(LO_ONES);
        rep_last = '0;
      end
      default: begin
        per_last = PW'(LO_PER - 1);
        ones     = PW'(LO_ONES);
        rep_last = RW'(LO_REPS - 1);
      end
    endcase
  end

  assign bit_o   = ph_q < ones;
  assign last_o  = (ph_q == per_last) && (rep_q == rep_last);
  assign fresh_o = (ph_q == '0) && (rep_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      rep_q <= '0;
    end else if (clr_i) begin
      ph_q  <= '0;
      rep_q <= '0;
    end else if (step_i) begin
      if (last_o) begin
        ph_q  <= '0;
        rep_q <= '0;
      end else if (ph_q == per_last) begin
        ph_q  <= '0;
        rep_q <= rep_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // R6
  sep_single_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == SEG_SEP) |-> (rep_q == '0));
  // R2
  phase_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < PW'(MAX_PER));
endmodule

// File: rtl/fsk_tag_seq.sv
module fsk_tag_seq
  import fsk_tag_pkg::*;
#(
  parameter int unsigned ID_W     = 44,
  parameter int unsigned SEP_SPAN = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic            seg_last_i,
  input  logic            fresh_i,
  input  logic [ID_W-1:0] id_i,
  output seg_e            kind_o
);
  localparam int unsigned BW = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [BW-1:0] TOP_BIT = BW'(ID_W - 1);
  localparam int unsigned SW = $clog2(SOF_GROUPS);

  st_e             st_q;
  logic [SW-1:0]   sof_q;
  logic [BW-1:0]   bit_q, nxt_bit;
  logic            half_q, to_sep, at_start;
  logic [ID_W-1:0] id_q;

  assign nxt_bit  = (st_q == ST_SOF) ? TOP_BIT : bit_q - 1'b1;
  assign to_sep   = (32'(nxt_bit) % SEP_SPAN) == (SEP_SPAN - 1);
  assign at_start = (st_q == ST_SOF) && (sof_q == '0) && fresh_i;

  always_comb begin
    unique case (st_q)
      ST_SOF:  kind_o = SOF_HI_MASK[sof_q] ? SEG_HI : SEG_LO;
      ST_SEP:  kind_o = SEG_SEP;
      default: kind_o = (id_q[bit_q] ^ half_q) ? SEG_HI : SEG_LO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q <= '0;
    end else if (step_i && at_start) begin
      id_q <= id_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SOF;
      sof_q  <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else if (clr_i) begin
      st_q   <= ST_SOF;
      sof_q  <= '0;
      half_q <= 1'b0;
    end else if (step_i && seg_last_i) begin
      unique case (st_q)
        ST_SOF: begin
          if (sof_q == SW'(SOF_GROUPS - 1)) begin
            sof_q  <= '0;
            bit_q  <= nxt_bit;
            half_q <= 1'b0;
            st_q   <= to_sep ? ST_SEP : ST_BIT;
          end else begin
            sof_q <= sof_q + 1'b1;
          end
        end
        ST_SEP: st_q <= ST_BIT;
        default: begin
          if (!half_q) begin
            half_q <= 1'b1;
          end else if (bit_q == '0) begin
            half_q <= 1'b0;
            st_q   <= ST_SOF;
          end else begin
            half_q <= 1'b0;
            bit_q  <= nxt_bit;
            st_q   <= to_sep ? ST_SEP : ST_BIT;
          end
        end
      endcase
    end
  end

  // R5
  bit_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i && seg_last_i && st_q == ST_BIT && !half_q)
      |=> (st_q == ST_BIT && half_q && $stable(bit_q)));
  // R6
  sep_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEP) |-> ((32'(bit_q) % SEP_SPAN) == (SEP_SPAN - 1)));
  // R8
  id_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && at_start) |=> $stable(id_q));
endmodule

// File: rtl/fsk_tag_gen.sv
module fsk_tag_gen
  import fsk_tag_pkg::*;
#(
  parameter int unsigned ID_W     = 44,
  parameter int unsigned SEP_SPAN = 4,
  parameter int unsigned LO_PER   = 8,
  parameter int unsigned LO_ONES  = 2,
  parameter int unsigned LO_REPS  = 6,
  parameter int unsigned HI_PER   = 10,
  parameter int unsigned HI_ONES  = 3,
  parameter int unsigned HI_REPS  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [ID_W-1:0] id_i,
  output logic            wave_o
);
  logic step, clr, seg_last, fresh, smp;
  seg_e kind;

  assign step = en_i & tick_i;
  assign clr  = ~en_i;

  fsk_tag_seq #(.ID_W(ID_W), .SEP_SPAN(SEP_SPAN)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .step_i     (step),
    .seg_last_i (seg_last),
    .fresh_i    (fresh),
    .id_i       (id_i),
    .kind_o     (kind)
  );

  fsk_tag_pat #(
    .LO_PER(LO_PER), .LO_ONES(LO_ONES), .LO_REPS(LO_REPS),
    .HI_PER(HI_PER), .HI_ONES(HI_ONES), .HI_REPS(HI_REPS)
  ) u_pat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .step_i  (step),
    .kind_i  (kind),
    .bit_o   (smp),
    .last_o  (seg_last),
    .fresh_o (fresh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wave_o <= 1'b0;
    else if (!en_i)   wave_o <= 1'b0;
    else if (tick_i)  wave_o <= smp;
  end

  // R1
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wave_o);
  // R9
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(wave_o));
endmodule

// File: tb/fsk_tag_gen_bench.sv
module fsk_tag_gen_bench;
  localparam int ID_W = 12;
  localparam int FR   = 8 * 49 + ID_W * 98 + 3 * 8; // 1592 samples

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0;
  logic            tick = 1'b0;
  logic [ID_W-1:0] id = '0;
  logic            wave;

  int    n_run = 0, n_fail = 0;
  bit    exp_q[$];
  string tag_q[$];
  logic  last_w = 1'b0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  fsk_tag_gen #(.ID_W(ID_W)) u_fsk_tag_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .id_i(id), .wave_o(wave)
  );

  task automatic push_per(int per, int ones, int reps, string tag);
    for (int r = 0; r < reps; r++)
      for (int p = 0; p < per; p++) begin
        exp_q.push_back(p < ones);
        tag_q.push_back(tag);
      end
  endtask

  // R2 low group, R3 high group
  task automatic push_group(bit hi, string tag);
    if (hi) push_per(10, 3, 5, {tag, " R3"});
    else    push_per(8, 2, 6, {tag, " R2"});
  endtask

  // R4 marker, R5 bits msb first, R6 separators
  task automatic push_frame(logic [ID_W-1:0] v, string pfx);
    bit mk[8] = '{0, 0, 0, 1, 1, 1, 0, 1};
    for (int g = 0; g < 8; g++) push_group(mk[g], {pfx, "R4"});
    for (int b = ID_W - 1; b >= 0; b--) begin
      if (b % 4 == 3) push_per(8, 2, 1, {pfx, "R6"});
      push_group(v[b], {pfx, "R5"});
      push_group(!v[b], {pfx, "R5"});
    end
  endtask

  task automatic run_ticks(int n, int gap, int chg_at, logic [ID_W-1:0] nid);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      if (i == chg_at) id = nid;
      if (gap > 0) begin
        @(negedge clk);
        tick = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    logic r_s, e_s, t_s;
    r_s = rst_n; e_s = en; t_s = tick;
    #1;
    if (!r_s || !e_s) begin
      n_run++;
      if (wave !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 R10: wave_o=%0b expected 0", wave);
      end
    end else if (t_s) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9: extra sample wave_o=%0b expected none", wave);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (wave !== e) begin
          n_fail++;
          $display("FAIL %s: wave_o=%0b expected %0b", t, wave, e);
        end
      end
    end else begin
      n_run++;
      if (wave !== last_w) begin
        n_fail++;
        $display("FAIL R9: wave_o=%0b expected %0b", wave, last_w);
      end
    end
    last_w = wave;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 ticks while disabled keep output low
    tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    id = 12'hA5C;
    en = 1'b1;
    push_frame(12'hA5C, "");
    // R8 second frame uses id seen at its start; R7 no gap
    push_frame(12'h3F1, "R7 R8 ");
    run_ticks(FR, 0, FR / 2, 12'h3F1);
    run_ticks(FR, 2, -1, '0);
    // R10 disable mid-frame
    push_frame(12'h0F0, "");
    id = 12'h0F0;
    run_ticks(500, 3, -1, '0);
    en = 1'b0;
    exp_q.delete();
    tag_q.delete();
    tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0;
    id = 12'h801;
    en = 1'b1;
    push_frame(12'h801, "R10 ");
    run_ticks(FR, 1, -1, '0);
    repeat (3) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9: %0d samples left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule